// File: doc/BRIEF.md
# Coincident Edge Sync Pulse Generator

This block flags the instants at which the bank-A and bank-C divided clocks rise together. Both banks are produced by dividers that run on one source clock. The block therefore reads the dividers' phase counters on that source clock and never samples the divided clocks from another domain. A bank rises in the source cycle in which its phase counter reads zero. A coincidence is a source cycle in which both counters read zero. The resulting sync pulse is most useful when the two banks are related by a non-binary ratio such as 3:2 or 4:3, where the shared edges are otherwise hard to find.

The sync pulse starts at a coincident edge. It lasts one period of the faster bank and falls at the next rising edge of either bank. When the two banks run at the same rate, every edge is shared, so the pulse is re-armed every period and stays high. A select bit chooses what the D output bank carries: the sync pulse, or a copy of the bank-C clock. The D output is registered, so both choices appear one source cycle after the inputs that produce them. A synchronous master reset clears the sync state and the D output together with the dividers, and the coincidence pattern then starts again from the dividers' common phase.

Top module: `coinc_sync_gen`

## Requirements
- R1: While `rst_n` is sampled low at a source-clock edge, `qd` and the internal sync state are 0 after that edge, even when both phase inputs read zero in the same cycle.
- R2: A source cycle in which `a_phase` and `c_phase` are both zero is a coincidence. With `sync_sel`=0 in that cycle, `qd` is 1 after the next edge.
- R3: A source cycle in which exactly one of `a_phase` and `c_phase` is zero ends the pulse. With `sync_sel`=0, `qd` is 0 after the next edge.
- R4: In a cycle in which neither phase is zero, the sync state keeps its value. The pulse therefore lasts exactly the faster bank's period in source cycles, and it stays high without a gap when the two banks have equal periods (1:1).
- R5: With `sync_sel`=1 in a cycle, `qd` after the next edge equals `c_clk` from that cycle. The sync state keeps running meanwhile.
- R6: Rising edges of only one bank, with the other bank's phase never zero, never raise the pulse.
- R7: The spacing between rising edges of `qd` (with `sync_sel`=0) is 2 A-periods at 2:1, 3 at 3:1, 3 at 3:2 (that is, 2 C-periods) and 4 at 4:3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Source clock shared with the bank dividers |
| rst_n | input | 1 | Synchronous active-low master reset |
| a_phase | input | PHASE_W | Bank-A divider phase; zero marks an A rising edge |
| c_phase | input | PHASE_W | Bank-C divider phase; zero marks a C rising edge |
| c_clk | input | 1 | Bank-C divided clock level, for the copy mode |
| sync_sel | input | 1 | 0: D carries the sync pulse; 1: D carries bank C |
| qd | output | 1 | Registered D-bank output |

## Verification
Two functions meet at each coincidence. The edge that starts a new pulse is also the faster bank's rise, and that rise would otherwise end the running pulse. The 1:1 run provokes this on every period, and the bench judges it by requiring `qd` to stay high without a single low cycle. Master reset also meets a coincidence: the bench holds both phases at zero throughout reset and expects `qd` low, so reset has to win over the start of a pulse.

// File: rtl/cs_pkg.sv
// Shared types for the coincident edge sync generator.
package cs_pkg;
    // Source selected for the D output bank.
    typedef enum logic {
        DSEL_SYNC  = 1'b0,
        DSEL_BANKC = 1'b1
    } dsel_e;
endpackage

// File: rtl/cs_bank_edge.sv
// Rising-edge detector for one bank.
// Assumes the bank divider is clocked by the same source clock and that
// its output rises in the source cycle in which its phase counter reads zero.
module cs_bank_edge #(
    parameter int PHASE_W = 4
) (
    input  logic [PHASE_W-1:0] phase,
    output logic               rise
);
    // Decode the zero phase as this bank's rising edge.
    always_comb begin
        rise = (phase == '0);
    end
endmodule

// File: rtl/cs_pulse_hold.sv
// Sync state for the pulse. A shared rise of both banks sets it; the
// rise of only one bank clears it; otherwise it holds. The next rise
// after a coincidence belongs to the faster bank, so the pulse lasts
// one faster-bank period.
// Assumes the rise strobes are one source cycle wide.
module cs_pulse_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic a_rise,
    input  logic c_rise,
    output logic sync_nxt,
    output logic sync_q
);
    logic both_rise;
    logic any_rise;

    // Classify this cycle's edges.
    always_comb begin
        both_rise = a_rise & c_rise;
        any_rise  = a_rise | c_rise;
    end

    // Next state: a shared edge wins over the end of the pulse.
    always_comb begin
        if (both_rise)
            sync_nxt = 1'b1;
        else if (any_rise)
            sync_nxt = 1'b0;
        else
            sync_nxt = sync_q;
    end

    // Hold the state; master reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= 1'b0;
        else
            sync_q <= sync_nxt;
    end
endmodule

// File: rtl/cs_dbank_mux.sv
// D-bank output stage: selects the sync pulse or a copy of bank C and
// registers the result, so both choices see the same one-cycle latency.
// Assumes c_clk is produced in the source-clock domain.
module cs_dbank_mux
    import cs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sync_nxt,
    input  logic c_clk,
    output logic qd_q
);
    dsel_e src;
    logic  qd_nxt;

    // Map the select pin onto the source type.
    always_comb begin
        src = dsel_e'(sel);
    end

    // Choose the value the D bank carries next.
    always_comb begin
        case (src)
            DSEL_BANKC: qd_nxt = c_clk;
            default:    qd_nxt = sync_nxt;
        endcase
    end

    // Register the D output; master reset drives it low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            qd_q <= 1'b0;
        else
            qd_q <= qd_nxt;
    end
endmodule

// File: rtl/coinc_sync_gen.sv
// Coincident edge sync generator top. Decodes both banks' rising edges
// from their divider phase counters, keeps the sync state and drives
// the D bank from the sync pulse or from bank C.
// Assumes both dividers share clk_src and the reset that clears this block.
module coinc_sync_gen #(
    parameter int PHASE_W = 4
) (
    input  logic               clk_src,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] a_phase,
    input  logic [PHASE_W-1:0] c_phase,
    input  logic               c_clk,
    input  logic               sync_sel,
    output logic               qd
);
    localparam int NBANK = 2;

    logic [NBANK-1:0][PHASE_W-1:0] bank_phase;
    logic [NBANK-1:0]              bank_rise;
    logic                          sync_nxt;
    logic                          sync_state;

    // Gather the bank phases: index 0 is bank A, index 1 is bank C.
    always_comb begin
        bank_phase[0] = a_phase;
        bank_phase[1] = c_phase;
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_edge
        cs_bank_edge #(.PHASE_W(PHASE_W)) u_edge (
            .phase (bank_phase[g]),
            .rise  (bank_rise[g])
        );
    end

    cs_pulse_hold u_hold (
        .clk      (clk_src),
        .rst_n    (rst_n),
        .a_rise   (bank_rise[0]),
        .c_rise   (bank_rise[1]),
        .sync_nxt (sync_nxt),
        .sync_q   (sync_state)
    );

    cs_dbank_mux u_mux (
        .clk      (clk_src),
        .rst_n    (rst_n),
        .sel      (sync_sel),
        .sync_nxt (sync_nxt),
        .c_clk    (c_clk),
        .qd_q     (qd)
    );
endmodule

// File: rtl/coinc_sync_gen_chk.sv
// Property checker for coinc_sync_gen, attached with bind below.
module coinc_sync_gen_chk #(
    parameter int PHASE_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PHASE_W-1:0] a_phase,
    input logic [PHASE_W-1:0] c_phase,
    input logic               c_clk,
    input logic               sync_sel,
    input logic               qd,
    input logic               sync_q
);
    logic a0;
    logic c0;
    assign a0 = (a_phase == '0);
    assign c0 = (c_phase == '0);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> !qd);

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (a0 && c0 && !sync_sel) |=> qd);

    p_single_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((a0 != c0) && !sync_sel) |=> !qd);

    p_hold_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!a0 && !c0 && sync_q) |=> sync_q);

    p_copy_c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sync_sel |=> (qd == $past(c_clk)));

    p_stay_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!a0 && !c0 && !sync_q) |=> !sync_q);
endmodule

bind coinc_sync_gen coinc_sync_gen_chk #(.PHASE_W(PHASE_W)) u_chk (
    .clk      (clk_src),
    .rst_n    (rst_n),
    .a_phase  (a_phase),
    .c_phase  (c_phase),
    .c_clk    (c_clk),
    .sync_sel (sync_sel),
    .qd       (qd),
    .sync_q   (sync_state)
);

// File: tb/coinc_sync_gen_test.sv
module coinc_sync_gen_test;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] a_phase = '0;
    logic [PW-1:0] c_phase = '0;
    logic          c_clk = 1'b0;
    logic          sync_sel = 1'b0;
    logic          qd;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int rem = 0;
    int last_rise = -1;
    int rise_gap = 0;
    logic prev_qd = 1'b0;
    bit   done = 1'b0;

    bit    exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    coinc_sync_gen #(.PHASE_W(PW)) uut (
        .clk_src (clk),
        .rst_n   (rst_n),
        .a_phase (a_phase),
        .c_phase (c_phase),
        .c_clk   (c_clk),
        .sync_sel(sync_sel),
        .qd      (qd)
    );

    // Monitor: pop one expected value per edge, compare, track pulse spacing.
    always @(posedge clk) begin
        #1;
        cyc++;
        if (exp_q.size() > 0) begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (qd !== e) begin
                n_bad++;
                $display("FAIL %s: qd actual %b expected %b at cycle %0d", t, qd, e, cyc);
            end
        end
        if (qd === 1'b1 && prev_qd === 1'b0 && sync_sel == 1'b0) begin
            if (last_rise >= 0) rise_gap = cyc - last_rise;
            last_rise = cyc;
        end
        prev_qd = qd;
    end

    // Driver: apply one cycle of inputs and push the value qd must take.
    task automatic drive(input logic rn, input int ap, input int cp,
                         input logic cc, input logic sel, input int per,
                         input string tag);
        bit coin;
        bit e;
        @(negedge clk);
        rst_n    = rn;
        a_phase  = PW'(ap);
        c_phase  = PW'(cp);
        c_clk    = cc;
        sync_sel = sel;
        coin = (ap == 0) && (cp == 0);
        if (!rn)       rem = 0;
        else if (coin) rem = per;
        else if (rem > 0) rem--;
        if (!rn)      e = 1'b0;
        else if (sel) e = cc;
        else          e = (rem > 0);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Reset for a few cycles with both phases at zero (reset beats coincidence).
    task automatic do_reset(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 0, 0, 1'b0, 1'b0, 1, "R1");
    endtask

    // Run both dividers; hold_a/hold_c pin a phase at 1 so that bank never rises.
    task automatic run(input int na, input int nc, input logic sel,
                       input bit hold_a, input bit hold_c, input int n,
                       input string tag);
        int per;
        per = (na < nc) ? na : nc;
        for (int i = 0; i < n; i++) begin
            int ap;
            int cp;
            ap = hold_a ? 1 : (i % na);
            cp = hold_c ? 1 : (i % nc);
            drive(1'b1, ap, cp, ((i % nc) < nc / 2), sel, per, tag);
        end
    endtask

    // Check the rise spacing of qd against the A-period count.
    task automatic check_gap(input int na, input int a_periods, input string tag);
        @(posedge clk);
        #2;
        n_cmp++;
        if (rise_gap != na * a_periods) begin
            n_bad++;
            $display("FAIL %s: rise spacing actual %0d expected %0d", tag, rise_gap, na * a_periods);
        end
    endtask

    task automatic new_run();
        do_reset(3);
        last_rise = -1;
        rise_gap  = 0;
    endtask

    initial begin
        do_reset(4);                              // R1 reset state
        new_run(); run(4, 4, 1'b0, 0, 0, 40, "R4");  // 1:1 stays high
        new_run(); run(4, 8, 1'b0, 0, 0, 80, "R2"); check_gap(4, 2, "R7");   // 2:1
        new_run(); run(2, 6, 1'b0, 0, 0, 60, "R3"); check_gap(2, 3, "R7");   // 3:1
        new_run(); run(4, 6, 1'b0, 0, 0, 96, "R4"); check_gap(4, 3, "R7");   // 3:2
        new_run(); run(6, 8, 1'b0, 0, 0, 120, "R2"); check_gap(6, 4, "R7");  // 4:3
        new_run(); run(4, 6, 1'b1, 0, 0, 48, "R5");  // D copies bank C
        new_run(); run(4, 6, 1'b0, 0, 1, 40, "R6");  // only A rises
        new_run(); run(4, 6, 1'b0, 1, 0, 40, "R6");  // only C rises
        run(6, 8, 1'b0, 0, 0, 30, "R3");
        do_reset(2);                              // R1 mid-run reset
        @(posedge clk);
        #2;
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        int t;
        t = 0;
        while (!done && t < 20000) begin
            @(posedge clk);
            t++;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule